// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Controller

This block fronts a working RAM that has a nonvolatile shadow copy, one shadow word for every working word. While idle it acts as a plain synchronous SRAM. Each clock edge samples chip enable, write enable, output enable, address and write data. Read data comes back one clock after the access.

The block can also move the whole memory in one bulk transfer. A STORE copies working words into the shadow. A RECALL first clears the working array and then fills it from the shadow. A transfer can be started by a power-fail strobe, a power-up strobe, an open-drain store/busy line, or six back-to-back reads at fixed addresses. While a transfer runs, every external access is dropped, the data outputs stay disabled, and the store/busy line is pulled low.

Both arrays are plain register arrays. Transfers move one word per clock through an internal index.

Top module: `nv_shadow_ram`

## Requirements
- R1: While idle, a write (ce_n=0, we_n=0) updates the addressed word. A read (ce_n=0, we_n=1) returns that word on rdata with dout_oe=1 in the following cycle, but only if oe_n was 0 at the read. A read with oe_n=1 leaves dout_oe at 0.
- R2: Six consecutive reads at the low AW address bits of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F start a STORE. The sixth read still returns its data. busy rises on the second edge after the sixth read and stays high for DEPTH+1 cycles.
- R3: The same first five addresses followed by 0x0F0E start a RECALL, with the same start timing. The clear pass and the copy pass take one cycle per word each, so busy stays high for 2*DEPTH+1 cycles. Afterwards every working word equals its shadow word.
- R4: An access that breaks a partial sequence aborts it. This covers any write, or any read at an address other than the next expected one. A read at the first sequence address restarts the sequence at step one. An aborted sequence never starts a transfer.
- R5: While busy is 1, writes do not reach the working array and reads produce no output (dout_oe stays 0).
- R6: While idle, hsb_in sampled low on two consecutive edges requests a STORE, and busy rises on the second of those edges. A low level seen on only one edge does nothing.
- R7: A store/busy-line STORE is skipped, so busy stays 0, when no write has been accepted since the last transfer began.
- R8: A pwr_fail pulse while idle always starts a STORE, even with no pending writes. A pwr_up pulse while idle starts a RECALL. Either one makes busy 1 from the next edge.
- R9: A RECALL leaves the shadow array unchanged, so repeated RECALLs restore the same image.
- R10: After reset, busy, dout_oe and hsb_pull_low are 0. hsb_pull_low is 1 exactly while busy is 1.
- R11: When several requests arrive on the same edge, a STORE request wins over a RECALL request. The order is pwr_fail, store/busy line, software store, pwr_up, software recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| dout_oe | output | 1 | Read data valid / output drive enable |
| pwr_fail | input | 1 | Power-fail strobe, requests STORE |
| pwr_up | input | 1 | Power-up strobe, requests RECALL |
| hsb_in | input | 1 | Sampled level of the open-drain store/busy line |
| hsb_pull_low | output | 1 | Pulls the store/busy line low while a transfer runs |
| busy | output | 1 | Transfer in progress |

## Verification
The bench targets the edges of the software sequence. It aborts a sequence with a write after five good reads, and with a stray read part way through. A matcher that ignores the abort would start a transfer with no sixth proper read, and busy would rise where it must stay low.

It also measures busy length for each kind of transfer. A RECALL that skips the clear pass, or a missing final cycle, shows up as a count one word or one pass short.

Writes and reads issued during a transfer are later read back. A design that lets them through would change a word or drive dout_oe while busy.

The store/busy line gets a one-edge glitch, a clean request that must be skipped, and a request that collides with power-up.

// File: rtl/nvs_pkg.sv
// Shared types and constants for the shadow-memory controller.
// Assumes the software sequence addresses are truncated to the array's
// address width (AW between 6 and 13 keeps all seven addresses distinct).
package nvs_pkg;

    // Transfer engine phase
    typedef enum logic [2:0] {
        XF_IDLE = 3'd0,
        XF_SAVE = 3'd1,
        XF_WIPE = 3'd2,
        XF_LOAD = 3'd3,
        XF_DONE = 3'd4
    } xfer_phase_e;

    // Full-width unlock addresses; steps 0..4 are shared, 5 ends a STORE,
    // 6 ends a RECALL.
    function automatic logic [12:0] seq_full(input logic [2:0] k);
        case (k)
            3'd0:    seq_full = 13'h0000;
            3'd1:    seq_full = 13'h1555;
            3'd2:    seq_full = 13'h0AAA;
            3'd3:    seq_full = 13'h1FFF;
            3'd4:    seq_full = 13'h10F0;
            3'd5:    seq_full = 13'h0F0F;
            default: seq_full = 13'h0F0E;
        endcase
    endfunction

endpackage

// File: rtl/nvs_seq_match.sv
// Software unlock matcher. Watches accepted accesses and steps through the
// six-read pattern; any write or off-pattern read aborts (R4). A match on the
// sixth read raises a one-cycle go pulse on the following cycle (R2, R3).
// Assumes acc is already qualified by the top (idle, no pending start).
module nvs_seq_match #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          acc_rd,
    input  logic [AW-1:0] addr,
    output logic          store_go,
    output logic          recall_go
);
    import nvs_pkg::*;

    localparam logic [2:0] LAST_STEP = 3'd5;

    logic [2:0]    step_q;
    logic [AW-1:0] want_a;
    logic [AW-1:0] first_a;
    logic [AW-1:0] st_end_a;
    logic [AW-1:0] rc_end_a;

    // Decode the address expected at the current step and the terminators
    always_comb begin
        want_a   = AW'(seq_full(step_q));
        first_a  = AW'(seq_full(3'd0));
        st_end_a = AW'(seq_full(3'd5));
        rc_end_a = AW'(seq_full(3'd6));
    end

    // Advance, abort or complete the pattern on every accepted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= 3'd0;
            store_go  <= 1'b0;
            recall_go <= 1'b0;
        end else begin
            store_go  <= 1'b0;
            recall_go <= 1'b0;
            if (acc) begin
                if (acc_rd && step_q < LAST_STEP && addr == want_a) begin
                    step_q <= step_q + 3'd1;
                end else if (acc_rd && step_q == LAST_STEP && addr == st_end_a) begin
                    step_q   <= 3'd0;
                    store_go <= 1'b1;
                end else if (acc_rd && step_q == LAST_STEP && addr == rc_end_a) begin
                    step_q    <= 3'd0;
                    recall_go <= 1'b1;
                end else begin
                    // abort; a read of the first address restarts at step one
                    step_q <= (acc_rd && addr == first_a) ? 3'd1 : 3'd0;
                end
            end
        end
    end

endmodule

// File: rtl/nvs_hsb_filter.sv
// Store/busy line handler. Requests a STORE after the line is seen low on two
// consecutive edges while idle (R6); one request per low period. Drives the
// open-drain pull-down for the whole transfer (R10).
// Assumes hsb_in is already synchronous to clk.
module nvs_hsb_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic hsb_in,
    input  logic busy,
    output logic hw_req,
    output logic pull_low
);
    logic low_q;
    logic fired_q;

    // Second consecutive low sample while idle and not yet used
    assign hw_req   = !hsb_in && low_q && !fired_q && !busy;
    assign pull_low = busy;

    // Remember last idle sample and whether this low period already fired
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            low_q <= !busy && !hsb_in;
            if (hsb_in)
                fired_q <= 1'b0;
            else if (hw_req)
                fired_q <= 1'b1;
        end
    end

endmodule

// File: rtl/nvs_xfer_engine.sv
// Bulk transfer sequencer. Arbitrates start requests (STORE over RECALL, R11),
// walks an index over every word, runs RECALL as clear pass then copy pass
// (R3), and holds one closing cycle before going idle. Tracks whether any
// write landed since the last transfer to gate line-requested stores (R7).
module nvs_xfer_engine #(
    parameter int AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_seen,
    input  logic                 req_pfail,
    input  logic                 req_hw,
    input  logic                 req_sw_store,
    input  logic                 req_pup,
    input  logic                 req_sw_recall,
    output nvs_pkg::xfer_phase_e phase,
    output logic [AW-1:0]        idx,
    output logic                 busy
);
    import nvs_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};
    localparam logic [AW-1:0] ONE      = AW'(1);

    logic dirty_q;
    logic go_store;
    logic go_recall;

    // Start decode: pwr_fail and software store always run, line store needs dirt
    always_comb begin
        go_store  = req_pfail || (req_hw && dirty_q) || req_sw_store;
        go_recall = req_pup || req_sw_recall;
    end

    assign busy = (phase != XF_IDLE);

    // Phase, index and dirty tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= XF_IDLE;
            idx     <= '0;
            dirty_q <= 1'b0;
        end else begin
            case (phase)
                XF_IDLE: begin
                    idx <= '0;
                    if (go_store) begin
                        phase   <= XF_SAVE;
                        dirty_q <= 1'b0;
                    end else if (go_recall) begin
                        phase   <= XF_WIPE;
                        dirty_q <= 1'b0;
                    end else if (wr_seen) begin
                        dirty_q <= 1'b1;
                    end
                end
                XF_SAVE: begin
                    if (idx == LAST_IDX) phase <= XF_DONE;
                    idx <= idx + ONE;
                end
                XF_WIPE: begin
                    if (idx == LAST_IDX) phase <= XF_LOAD;
                    idx <= idx + ONE;
                end
                XF_LOAD: begin
                    if (idx == LAST_IDX) phase <= XF_DONE;
                    idx <= idx + ONE;
                end
                default: phase <= XF_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nv_shadow_ram.sv
// Top: working RAM with a nonvolatile shadow array and bulk STORE/RECALL.
// Idle accesses are synchronous; read data is registered (R1). Accesses are
// dropped while a transfer runs or a software start is pending (R5).
// Assumes all inputs are synchronous to clk. Arrays carry no reset.
module nv_shadow_ram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          dout_oe,
    input  logic          pwr_fail,
    input  logic          pwr_up,
    input  logic          hsb_in,
    output logic          hsb_pull_low,
    output logic          busy
);
    import nvs_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ram_q    [DEPTH];
    logic [DW-1:0] shadow_q [DEPTH];
    logic [DW-1:0] rdata_q;
    logic          rd_q;
    logic          acc, acc_rd, acc_wr;
    logic          store_go, recall_go, hw_req;
    xfer_phase_e   phase;
    logic [AW-1:0] idx;

    // Accept an access only when idle and no software start is pending
    always_comb begin
        acc    = !ce_n && !busy && !store_go && !recall_go;
        acc_rd = acc && we_n;
        acc_wr = acc && !we_n;
    end

    nvs_seq_match #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .acc_rd    (acc_rd),
        .addr      (addr),
        .store_go  (store_go),
        .recall_go (recall_go)
    );

    nvs_hsb_filter u_hsb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsb_in   (hsb_in),
        .busy     (busy),
        .hw_req   (hw_req),
        .pull_low (hsb_pull_low)
    );

    nvs_xfer_engine #(.AW(AW)) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_seen       (acc_wr),
        .req_pfail     (pwr_fail),
        .req_hw        (hw_req),
        .req_sw_store  (store_go),
        .req_pup       (pwr_up),
        .req_sw_recall (recall_go),
        .phase         (phase),
        .idx           (idx),
        .busy          (busy)
    );

    // Array update: bulk transfer owns the arrays, else external writes
    always_ff @(posedge clk) begin
        case (phase)
            XF_SAVE: shadow_q[idx] <= ram_q[idx];
            XF_WIPE: ram_q[idx]    <= '0;
            XF_LOAD: ram_q[idx]    <= shadow_q[idx];
            default: if (acc_wr) ram_q[addr] <= wdata;
        endcase
    end

    // Registered read port and output enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rd_q    <= 1'b0;
        end else begin
            rd_q <= acc_rd && !oe_n;
            if (acc_rd) rdata_q <= ram_q[addr];
        end
    end

    assign rdata   = rdata_q;
    assign dout_oe = rd_q && !busy;

endmodule

// File: rtl/nvs_checker.sv
// Temporal checks for nv_shadow_ram, attached by bind. Busy length is counted
// here rather than through a long $past window.
module nvs_checker #(
    parameter int AW = 6
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic pwr_fail,
    input logic pwr_up,
    input logic busy,
    input logic dout_oe
);
    localparam int N = 1 << AW;
    localparam logic [AW+1:0] LEN_ST = (AW+2)'(N + 1);
    localparam logic [AW+1:0] LEN_RC = (AW+2)'(2 * N + 1);

    logic [AW+1:0] run_q;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= busy ? run_q + 1'b1 : '0;
    end

    p_read_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!ce_n && we_n && !oe_n));

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (run_q == LEN_ST || run_q == LEN_RC));

    p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_oe);

    p_pfail_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !busy) |=> busy);

    p_pup_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && !busy) |=> busy);

endmodule

bind nv_shadow_ram nvs_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .pwr_fail (pwr_fail),
    .pwr_up   (pwr_up),
    .busy     (busy),
    .dout_oe  (dout_oe)
);

// File: tb/sim_nv_shadow_ram.sv
module sim_nv_shadow_ram;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic dout_oe, busy, pull;
    logic pwr_fail = 1'b0, pwr_up = 1'b0, ext_low = 1'b0;
    wire  hsb_line;
    assign hsb_line = ~(ext_low | pull);

    always #2 clk = ~clk;

    nv_shadow_ram #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .dout_oe(dout_oe),
        .pwr_fail(pwr_fail), .pwr_up(pwr_up), .hsb_in(hsb_line),
        .hsb_pull_low(pull), .busy(busy)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    logic [DW-1:0] ram_m [N];
    logic [DW-1:0] shadow_m [N];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    localparam logic [AW-1:0] S0 = 6'h00, S1 = 6'h15, S2 = 6'h2A, S3 = 6'h3F,
                              S4 = 6'h30, SST = 6'h0F, SRC = 6'h0E;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected read data whenever the design drives it
    always @(negedge clk) begin
        if (rst_n && !finished && dout_oe) begin
            if (exp_q.size() == 0) chk(0, "R5", "unexpected dout_oe", 1, 0);
            else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata == e, t, "read data", rdata, e);
            end
        end
    end

    // Driver: one access per cycle; model updated only when told to
    task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit oe_low, input bit live, input string tag);
        ce_n = 1'b0; we_n = !wr; oe_n = !oe_low; addr = a; wdata = d;
        if (live && wr) ram_m[a] = d;
        if (live && !wr && oe_low) begin exp_q.push_back(ram_m[a]); tag_q.push_back(tag); end
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        op(0, a, '0, 1, 1, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        op(1, a, d, 0, 1, "R1");
    endtask

    // Count busy cycles from the current sample; also check the pull-down
    task automatic measure(input int exp, input string tag);
        int n = 0;
        int pbad = 0;
        while (busy === 1'b1 && n < 1000) begin
            if (pull !== 1'b1) pbad++;
            n++;
            @(negedge clk);
        end
        chk(n == exp, tag, "busy length", n, exp);
        chk(pbad == 0 && pull == 1'b0, "R10", "pull-down tracks busy", pbad, 0);
    endtask

    task automatic quiet(input int cyc, input string tag);
        int hits = 0;
        for (int i = 0; i < cyc; i++) begin
            if (busy) hits++;
            @(negedge clk);
        end
        chk(hits == 0, tag, "no transfer started", hits, 0);
    endtask

    task automatic sw_seq(input logic [AW-1:0] last, input string tag);
        rd(S0, tag); rd(S1, tag); rd(S2, tag); rd(S3, tag); rd(S4, tag); rd(last, tag);
        chk(busy == 1'b0, tag, "busy after sixth read", busy, 0);
        @(negedge clk);
    endtask

    task automatic do_store_model();
        for (int i = 0; i < N; i++) shadow_m[i] = ram_m[i];
    endtask

    task automatic do_recall_model();
        for (int i = 0; i < N; i++) ram_m[i] = shadow_m[i];
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < N; i++) rd(AW'(i), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(busy == 0 && dout_oe == 0 && pull == 0, "R10", "reset outputs",
            {busy, dout_oe, pull}, 0);

        // R1: fill, read back, read with output disabled
        for (int i = 0; i < N; i++) wr(AW'(i), DW'(i * 3 + 7));
        rd(6'd4, "R1"); rd(6'd63, "R1");
        op(0, 6'd9, '0, 0, 1, "R1");
        chk(dout_oe == 0, "R1", "oe_n high read drives nothing", dout_oe, 0);

        // R2: software store
        sw_seq(SST, "R2");
        measure(N + 1, "R2");
        do_store_model();

        // R3: overwrite, then software recall restores shadow image
        wr(6'd1, 8'hA1); wr(6'd40, 8'hB2); wr(6'd63, 8'hC3);
        sw_seq(SRC, "R3");
        measure(2 * N + 1, "R3");
        do_recall_model();
        rd(6'd1, "R3"); rd(6'd40, "R3"); rd(6'd63, "R3");

        // R8, R9: write, then power-up recall gives the same image again
        wr(6'd2, 8'h5A); wr(6'd50, 8'h66);
        pwr_up = 1; @(negedge clk); pwr_up = 0;
        measure(2 * N + 1, "R8");
        do_recall_model();
        rd(6'd2, "R9"); rd(6'd50, "R9");

        // R7: clean state, line request is skipped
        ext_low = 1; @(negedge clk); @(negedge clk); ext_low = 0;
        quiet(3, "R7");

        // R6: dirty, two-edge low starts a store
        wr(6'd7, 8'h77);
        ext_low = 1; @(negedge clk); @(negedge clk); ext_low = 0;
        chk(busy == 1, "R6", "line store started", busy, 1);
        measure(N + 1, "R6");
        do_store_model();

        // R6: one-edge glitch does nothing
        wr(6'd8, 8'h88);
        ext_low = 1; @(negedge clk); ext_low = 0;
        quiet(3, "R6");

        // R5: accesses during a power-fail store are ignored
        pwr_fail = 1; @(negedge clk); pwr_fail = 0;
        op(1, 6'd5, 8'hEE, 0, 0, "R5");
        op(0, 6'd5, '0, 1, 0, "R5");
        measure(N - 1, "R5");
        do_store_model();
        rd(6'd5, "R5");

        // R8: power-fail store runs even when clean
        pwr_fail = 1; @(negedge clk); pwr_fail = 0;
        measure(N + 1, "R8");

        // R11: simultaneous power-fail and power-up: store wins
        wr(6'd20, 8'h20);
        pwr_fail = 1; pwr_up = 1; @(negedge clk); pwr_fail = 0; pwr_up = 0;
        measure(N + 1, "R11");
        do_store_model();
        wr(6'd20, 8'hFF);
        pwr_up = 1; @(negedge clk); pwr_up = 0;
        measure(2 * N + 1, "R11");
        do_recall_model();
        rd(6'd20, "R11");

        // R4: write after five good reads aborts
        rd(S0, "R4"); rd(S1, "R4"); rd(S2, "R4"); rd(S3, "R4"); rd(S4, "R4");
        wr(6'd33, 8'h33);
        rd(SST, "R4");
        quiet(3, "R4");
        // R4: stray read mid-sequence aborts
        rd(S0, "R4"); rd(S1, "R4"); rd(S2, "R4"); rd(6'd34, "R4");
        rd(S3, "R4"); rd(S4, "R4"); rd(SRC, "R4");
        quiet(3, "R4");
        // R4: read of first address restarts at step one
        rd(S0, "R4"); rd(S1, "R4"); rd(S0, "R4");
        sw_seq(SST, "R4");
        measure(N + 1, "R4");
        do_store_model();

        read_all("R1");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "all expected reads seen", exp_q.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule